// File: doc/BRIEF.md
# Streaming CRC Engine

This block computes a cyclic redundancy check over a stream of bytes, taking one byte on every beat where `in_valid` is high. Inside each beat, the byte is folded into the remainder register by a bit-serial division loop. That loop is unrolled eight times, so the block keeps up with one byte per clock. Three parameters fix the arithmetic: the CRC width (8, 16 or 32 bits), the generator polynomial and the start value. The polynomial's leading coefficient is always one, so it is implied and not stored.

A frame opens with a beat that has `in_sof` high and closes with a beat that has `in_eof` high. One cycle after the closing beat, the block presents the result together with a one-cycle done pulse. Three static configuration inputs shape each frame:
- Bit order within a byte: least-significant bit first, for serial links that send bytes that way.
- Final pattern: whether the `XOR_OUT` pattern is applied to the result.
- Byte order: whether the bytes of the result are presented in reverse order.

On the receive side, a frame can carry its own CRC at the end. The block then raises a check flag when the remainder left over from the whole frame equals the expected residue.

Top module: `crc_stream_engine`

## Requirements
- R1: With MSB-first order, no final pattern and no swap, the bytes are divided MSB first by the polynomial `POLY`, whose top coefficient is implied. For CRC_W=16, POLY=16'h1021 and INIT=16'hFFFF, the ASCII string "123456789" gives 16'h29B1.
- R2: A beat with `in_sof` high loads `INIT` into the remainder before its byte is folded in. A new frame therefore does not depend on earlier frames.
- R3: A beat without `in_sof` continues from the current remainder. Cycles with `in_valid` low leave the remainder unchanged, so idle gaps inside a frame do not alter the result.
- R4: With `cfg_lsb_first` high, the bits of each byte are taken bit 0 first. This gives the same result as MSB-first processing of the bit-mirrored byte.
- R5: `crc_done` is high for exactly one cycle, and `crc_out` is updated, on the clock edge that follows the edge at which an `in_eof` beat is accepted.
- R6: With `cfg_final_xor_en` high, the result is XORed with `XOR_OUT` (default 16'hFFFF). For "123456789" this gives 16'hD64E.
- R7: With `cfg_byte_swap` high, the bytes of the result are presented in reverse order. For 16 bits, the two bytes are swapped, so "123456789" gives 16'hB129.
- R8: `chk_ok` rises together with `crc_done` when the raw remainder after the last byte is the expected residue. Without the final pattern the residue is zero. With the final pattern it is the remainder of `XOR_OUT` divided into a zero register. A frame with its transmitted CRC appended, high byte first in the frame's bit order, therefore checks good, and a single flipped bit checks bad.
- R9: `crc_out` holds its value between done pulses, including across idle cycles and across the beats of the next frame before its end.
- R10: After reset, `crc_done` and `chk_ok` are 0 and `crc_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_lsb_first | input | 1 | Take each byte bit 0 first |
| cfg_final_xor_en | input | 1 | Apply XOR_OUT to the result and the check residue |
| cfg_byte_swap | input | 1 | Reverse the byte order of the result |
| in_valid | input | 1 | Byte beat accepted this cycle |
| in_data | input | 8 | Byte of the frame |
| in_sof | input | 1 | Beat is the first of a frame |
| in_eof | input | 1 | Beat is the last of a frame |
| crc_out | output | CRC_W | Result of the last finished frame |
| crc_done | output | 1 | One-cycle pulse when crc_out is new |
| chk_ok | output | 1 | Frame remainder equals the residue (with crc_done) |

## Verification
The bench uses several kinds of frame:
- The standard nine-digit ASCII string, under each output option, which pins the polynomial division, the final pattern and the byte swap against known constants.
- The same bytes with idle gaps inserted, and frames sent back to back, which separate a correct reload on start-of-frame from state carried over from an earlier frame.
- The same bytes in both bit orders, which show whether the bits of each byte are mirrored.
- Frames with their own CRC appended, once intact and once with a single bit flipped, under both residue settings, which exercise the check flag.

A reference model in the bench predicts every result, and a monitor checks that each one appears exactly one cycle after its last byte.

// File: rtl/crc_eng_pkg.sv
package crc_eng_pkg;

   // Mirror the bit order of a byte.
   function automatic logic [7:0] mirror8(input logic [7:0] b);
      logic [7:0] m;
      for (int i = 0; i < 8; i++) m[i] = b[7-i];
      return m;
   endfunction

endpackage

// File: rtl/crc_fold_unit.sv
// Folds one byte, MSB first, into the remainder through eight unrolled division steps.
module crc_fold_unit #(
   parameter int unsigned CRC_W = 16,
   parameter logic [CRC_W-1:0] POLY = 16'h1021
) (
   input  logic [CRC_W-1:0] rem_i,
   input  logic [7:0]       byte_i,
   output logic [CRC_W-1:0] rem_o
);
   localparam int unsigned STEPS = 8;

   logic [CRC_W-1:0] stage [STEPS+1];

   assign stage[0] = rem_i;

   for (genvar k = 0; k < STEPS; k++) begin : g_step
      logic fb;
      assign fb = stage[k][CRC_W-1] ^ byte_i[STEPS-1-k];
      assign stage[k+1] = {stage[k][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
   end

   assign rem_o = stage[STEPS];
endmodule

// File: rtl/crc_out_stage.sv
// Applies the optional final pattern and the optional byte reversal.
module crc_out_stage #(
   parameter int unsigned CRC_W = 16,
   parameter logic [CRC_W-1:0] XOR_OUT = 16'hFFFF
) (
   input  logic [CRC_W-1:0] rem_i,
   input  logic             xor_en_i,
   input  logic             swap_i,
   output logic [CRC_W-1:0] crc_o
);
   localparam int unsigned NBYTES = CRC_W / 8;

   logic [CRC_W-1:0] xored;
   logic [CRC_W-1:0] swapped;

   assign xored = xor_en_i ? (rem_i ^ XOR_OUT) : rem_i;

   if (NBYTES == 1) begin : g_single
      assign swapped = xored;
   end else begin : g_multi
      for (genvar b = 0; b < NBYTES; b++) begin : g_lane
         assign swapped[8*b +: 8] = xored[8*(NBYTES-1-b) +: 8];
      end
   end

   assign crc_o = swap_i ? swapped : xored;
endmodule

// File: rtl/crc_stream_engine.sv
module crc_stream_engine #(
   parameter int unsigned CRC_W = 16,
   parameter logic [CRC_W-1:0] POLY    = 16'h1021,
   parameter logic [CRC_W-1:0] INIT    = 16'hFFFF,
   parameter logic [CRC_W-1:0] XOR_OUT = 16'hFFFF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_lsb_first,
   input  logic             cfg_final_xor_en,
   input  logic             cfg_byte_swap,
   input  logic             in_valid,
   input  logic [7:0]       in_data,
   input  logic             in_sof,
   input  logic             in_eof,
   output logic [CRC_W-1:0] crc_out,
   output logic             crc_done,
   output logic             chk_ok
);
   import crc_eng_pkg::*;

   if (!(CRC_W == 8 || CRC_W == 16 || CRC_W == 32)) begin : g_bad_width
      $error("crc_stream_engine: CRC_W must be 8, 16 or 32");
   end
   if (POLY[0] != 1'b1) begin : g_bad_poly
      $error("crc_stream_engine: POLY must have its constant term set");
   end

   // Remainder of XOR_OUT divided into a zero register: the good-frame residue
   // when the final pattern is in use.
   function automatic logic [CRC_W-1:0] calc_residue();
      logic [CRC_W-1:0] r;
      logic fb;
      r = '0;
      for (int i = CRC_W - 1; i >= 0; i--) begin
         fb = r[CRC_W-1] ^ XOR_OUT[i];
         r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
      end
      return r;
   endfunction

   localparam logic [CRC_W-1:0] RESIDUE = calc_residue();

   logic [CRC_W-1:0] rem_q;
   logic [CRC_W-1:0] rem_base;
   logic [CRC_W-1:0] rem_next;
   logic [7:0]       byte_ord;
   logic [CRC_W-1:0] crc_fin;
   logic [CRC_W-1:0] crc_q;
   logic             done_q;
   logic             chk_q;
   logic             last_beat;
   logic             rem_match;

   assign rem_base  = in_sof ? INIT : rem_q;
   assign byte_ord  = cfg_lsb_first ? mirror8(in_data) : in_data;
   assign last_beat = in_valid & in_eof;
   assign rem_match = (rem_next == (cfg_final_xor_en ? RESIDUE : '0));

   crc_fold_unit #(.CRC_W(CRC_W), .POLY(POLY)) u_fold (
      .rem_i  (rem_base),
      .byte_i (byte_ord),
      .rem_o  (rem_next)
   );

   crc_out_stage #(.CRC_W(CRC_W), .XOR_OUT(XOR_OUT)) u_out (
      .rem_i    (rem_next),
      .xor_en_i (cfg_final_xor_en),
      .swap_i   (cfg_byte_swap),
      .crc_o    (crc_fin)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q  <= INIT;
         crc_q  <= '0;
         done_q <= 1'b0;
         chk_q  <= 1'b0;
      end else begin
         done_q <= last_beat;
         chk_q  <= last_beat & rem_match;
         if (in_valid)  rem_q <= rem_next;
         if (last_beat) crc_q <= crc_fin;
      end
   end

   assign crc_out  = crc_q;
   assign crc_done = done_q;
   assign chk_ok   = chk_q;
endmodule

// File: rtl/crc_stream_engine_chk.sv
module crc_stream_engine_chk #(
   parameter int unsigned CRC_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_eof,
   input logic [CRC_W-1:0] crc_out,
   input logic             crc_done,
   input logic             chk_ok
);
   // R5: a done pulse follows every accepted end-of-frame beat
   p_done_follows_eof_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_eof) |=> crc_done);

   // R5: a done pulse never appears without an end-of-frame beat before it
   p_done_needs_eof_r5: assert property (@(posedge clk) disable iff (!rst_n)
      crc_done |-> $past(in_valid && in_eof));

   // R9: the result is held whenever no frame ends
   p_out_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && in_eof) |=> $stable(crc_out));

   // R8: the check flag only appears alongside a done pulse
   p_chk_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      chk_ok |-> crc_done);
endmodule

bind crc_stream_engine crc_stream_engine_chk #(.CRC_W(CRC_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_eof   (in_eof),
   .crc_out  (crc_out),
   .crc_done (crc_done),
   .chk_ok   (chk_ok)
);

// File: tb/crc_stream_engine_tb_top.sv
module crc_stream_engine_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int W = 16;
   localparam logic [W-1:0] T_POLY = 16'h1021;
   localparam logic [W-1:0] T_INIT = 16'hFFFF;
   localparam logic [W-1:0] T_XOR  = 16'hFFFF;

   typedef struct {
      logic [W-1:0] crc;
      bit           chk;
      int           cyc;
      string        tag;
   } exp_t;

   logic clk = 0, rst_n = 0;
   logic cfg_lsb_first = 0, cfg_final_xor_en = 0, cfg_byte_swap = 0;
   logic in_valid = 0, in_sof = 0, in_eof = 0;
   logic [7:0] in_data = 0;
   logic [W-1:0] crc_out;
   logic crc_done, chk_ok;

   int checks = 0, errors = 0, cyc = 0;
   exp_t exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   crc_stream_engine dut_i (
      .clk(clk), .rst_n(rst_n),
      .cfg_lsb_first(cfg_lsb_first), .cfg_final_xor_en(cfg_final_xor_en),
      .cfg_byte_swap(cfg_byte_swap),
      .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
      .crc_out(crc_out), .crc_done(crc_done), .chk_ok(chk_ok)
   );

   // Reference model: division one bit at a time in the chosen order.
   function automatic logic [W-1:0] ref_byte(logic [W-1:0] r, logic [7:0] d, bit lsb);
      for (int n = 0; n < 8; n++) begin
         logic b;
         b = lsb ? d[n] : d[7-n];
         if (r[W-1] ^ b) r = (r << 1) ^ T_POLY;
         else            r = r << 1;
      end
      return r;
   endfunction

   function automatic logic [W-1:0] ref_raw(logic [7:0] q[$], bit lsb);
      logic [W-1:0] r = T_INIT;
      foreach (q[i]) r = ref_byte(r, q[i], lsb);
      return r;
   endfunction

   function automatic logic [W-1:0] ref_residue();
      logic [W-1:0] r = '0;
      r = ref_byte(r, T_XOR[15:8], 0);
      r = ref_byte(r, T_XOR[7:0], 0);
      return r;
   endfunction

   function automatic logic [7:0] flip8(logic [7:0] b);
      logic [7:0] m;
      for (int n = 0; n < 8; n++) m[n] = b[7-n];
      return m;
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   task automatic beat(logic [7:0] d, bit sof, bit eof);
      @(negedge clk);
      in_valid = 1; in_data = d; in_sof = sof; in_eof = eof;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 0; in_sof = 0; in_eof = 0; in_data = 8'hA5;
      end
   endtask

   // Driver: sends a frame and pushes the predicted result.
   // exp_chk: -1 = from model, 0/1 = forced; exp_crc_force used when use_force set.
   task automatic send_frame(logic [7:0] q[$], bit lsb, bit xr, bit sw, int gap,
                             int exp_chk, bit use_force, logic [W-1:0] forced, string tag);
      exp_t e;
      logic [W-1:0] raw, fin;
      @(negedge clk);
      in_valid = 0;
      cfg_lsb_first = lsb; cfg_final_xor_en = xr; cfg_byte_swap = sw;
      raw = ref_raw(q, lsb);
      fin = xr ? raw ^ T_XOR : raw;
      if (sw) fin = {fin[7:0], fin[15:8]};
      e.crc = use_force ? forced : fin;
      e.chk = (exp_chk >= 0) ? bit'(exp_chk) : (raw == (xr ? ref_residue() : '0));
      e.tag = tag;
      foreach (q[i]) begin
         beat(q[i], i == 0, i == q.size() - 1);
         if (i == q.size() - 1) begin
            e.cyc = cyc + 1;
            exp_q.push_back(e);
         end
         if (gap > 0 && i != q.size() - 1) idle(gap);
      end
      idle(1);
   endtask

   // Monitor: pops predictions as results appear.
   always @(negedge clk) begin
      if (rst_n && crc_done) begin
         if (exp_q.size() == 0) begin
            check("R5 unexpected done pulse", 1, 0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check({e.tag, " crc_out"}, crc_out, e.crc);
            check({e.tag, " R8 chk_ok"}, chk_ok, e.chk);
            check({e.tag, " R5 done cycle"}, cyc, e.cyc);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] s[$], a[$], b[$];
      logic [W-1:0] r, held;
      s = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};

      repeat (3) @(negedge clk);
      check("R10 reset crc_done", crc_done, 0);
      check("R10 reset chk_ok", chk_ok, 0);
      check("R10 reset crc_out", crc_out, 0);
      @(negedge clk); rst_n = 1;
      idle(2);

      send_frame(s, 0, 0, 0, 0, -1, 1, 16'h29B1, "R1 R2 check string");
      send_frame(s, 0, 1, 0, 0, -1, 1, 16'hD64E, "R6 final pattern");
      send_frame(s, 0, 0, 1, 0, -1, 1, 16'hB129, "R7 byte swap");
      send_frame(s, 0, 1, 1, 0, -1, 1, 16'h4ED6, "R6 R7 combined");
      send_frame(s, 0, 0, 0, 3, -1, 1, 16'h29B1, "R3 idle gaps");

      // R4: LSB-first equals MSB-first over mirrored bytes
      b = {};
      foreach (s[i]) b.push_back(flip8(s[i]));
      send_frame(s, 1, 0, 0, 0, -1, 1, ref_raw(b, 0), "R4 lsb first");
      send_frame(s, 1, 0, 0, 1, -1, 0, '0, "R4 lsb first gaps");

      // R2: back-to-back frames, the second reloads INIT
      a = '{8'h00};
      send_frame(a, 0, 0, 0, 0, -1, 0, '0, "R2 single byte frame");
      a = '{8'hFF, 8'h00, 8'h5A};
      send_frame(a, 0, 0, 0, 0, -1, 0, '0, "R2 reload frame a");
      send_frame(a, 0, 0, 0, 0, -1, 0, '0, "R2 reload frame b");

      // R8: frames carrying their own CRC
      r = ref_raw(s, 0);
      a = s; a.push_back(r[15:8]); a.push_back(r[7:0]);
      send_frame(a, 0, 0, 0, 0, 1, 0, '0, "R8 good frame plain");
      r = ref_raw(s, 0) ^ T_XOR;
      a = s; a.push_back(r[15:8]); a.push_back(r[7:0]);
      send_frame(a, 0, 1, 0, 0, 1, 0, '0, "R8 good frame residue");
      send_frame(a, 0, 1, 1, 0, 1, 0, '0, "R8 good frame swapped out");
      a[3] = a[3] ^ 8'h04;
      send_frame(a, 0, 1, 0, 0, 0, 0, '0, "R8 corrupted frame");
      r = ref_raw(s, 1);
      a = s; a.push_back(flip8(r[15:8])); a.push_back(flip8(r[7:0]));
      send_frame(a, 1, 0, 0, 2, 1, 0, '0, "R8 good frame lsb first");

      // R9: output held over idle cycles and an unfinished frame
      idle(2);
      held = crc_out;
      idle(5);
      check("R9 held over idle", crc_out, held);
      beat(8'h12, 1, 0); beat(8'h34, 0, 0);
      idle(1);
      check("R9 held mid frame", crc_out, held);
      check("R5 no done mid frame", crc_done, 0);
      beat(8'h56, 0, 1);
      begin
         exp_t e;
         a = '{8'h12, 8'h34, 8'h56};
         e.crc = ref_raw(a, 1) ^ 16'h0000;
         e.chk = (ref_raw(a, 1) == 16'h0000);
         e.cyc = cyc + 1;
         e.tag = "R3 resumed frame";
         exp_q.push_back(e);
      end
      idle(4);

      check("R5 all results seen", exp_q.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule